// File: doc/BRIEF.md
# Instruction Prefetch Queue

This block sits between the instruction fetch path and the execution unit of a processor whose opcodes and extension words are 16 bits wide. Every fetch delivers a 32-bit long word. The block splits that long word into an upper and a lower half and holds both in an input stage. From there, words move through a holding stage to a decode stage. Each of the three storage points has its own valid flag. A word moves into a later stage as soon as that stage is empty, with no request from the execution unit.

The execution unit controls the queue with two requests. It raises `use_mid` when it has consumed the word in the holding stage. It raises `start_insn` when a new instruction begins, which copies the holding word into the decode stage. Both requests empty the holding stage, and the holding stage then refills from the input stage in the same edge. Two registered active-low lines report these events, one clock cycle wide and aligned to the system clock, so an observer can sample them on the falling edge. A synchronous `flush` empties the queue after a branch.

Top module: `ipq_top`

## Requirements
- R1: After reset, `mid_valid` and `dec_valid` are 0, `fetch_req` is 1, and `used_n` and `start_n` are 1.
- R2: A fetched long word is delivered as two words. Bits 31..16 reach the holding stage first, and bits 15..0 follow as the next word.
- R3: When the holding stage is empty, or is being emptied, and the input stage holds a word, that word is in the holding stage after the next rising edge. No request is needed.
- R4: With `mid_valid` = 1, a `use_mid` pulse empties the holding stage. The holding stage becomes valid again at the same edge only if the input stage had a word.
- R5: With `mid_valid` = 1, a `start_insn` pulse loads the holding word into the decode stage and sets `dec_valid`. It also advances the holding stage, as in R4. Only such a start changes `dec_word`.
- R6: `fetch_req` is 1 exactly when both input halves are empty. `fetch_valid` loads both halves only while `fetch_req` is 1, and is ignored otherwise.
- R7: `used_n` is 0 for the single cycle after each edge at which `use_mid` was accepted (`mid_valid` = 1). Otherwise it is 1.
- R8: `start_n` is 0 for the single cycle after each edge at which `start_insn` was accepted (`mid_valid` = 1). Otherwise it is 1.
- R9: When `use_mid` and `start_insn` are both accepted at one edge, the queue advances only once, and both status lines are 0 together in the next cycle.
- R10: A `flush` at a rising edge empties all stages after that edge and raises `fetch_req`. It takes priority over all other inputs, and neither status line goes low for that edge.
- R11: While `mid_valid` = 0, `use_mid` and `start_insn` have no effect. The status lines stay 1 and the decode stage is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Synchronous clear of all stages |
| fetch_req | output | 1 | Input stage empty, long-word fetch wanted |
| fetch_valid | input | 1 | Fetch data present on `fetch_data` |
| fetch_data | input | 32 | Fetched long word |
| use_mid | input | 1 | Execution unit consumed the holding word |
| start_insn | input | 1 | New instruction begins |
| mid_valid | output | 1 | Holding stage valid |
| mid_word | output | 16 | Holding stage word |
| dec_valid | output | 1 | Decode stage valid |
| dec_word | output | 16 | Decode stage word |
| used_n | output | 1 | Low for one cycle after a consume |
| start_n | output | 1 | Low for one cycle after an instruction start |

## Verification
Directed phases each try one kind of input pattern against a behavioural word-queue model:
- **Fetch then drain.** A single fetch followed by idle cycles shows whether the halves come out in the right order and move forward without a request.
- **Back-to-back consumes with fetch held high.** This shows whether the refill timing is right and whether fetches are refused while the input stage holds words.
- **Starts alone and combined with consumes.** These separate a single advance from a double advance, and show whether each status line fires on its own.
- **Requests while the queue is empty, and a flush with fetch data present.** These show that an empty holding stage blocks both requests and that the clear takes priority.

A long pseudo-random phase then mixes all of these inputs.

// File: rtl/ipq_pkg.sv
package ipq_pkg;
  localparam int IPQ_WORD_W = 16;
  localparam int IPQ_HALVES = 2;
  localparam int IPQ_NSTAT  = 2;

  // status event vector bit positions
  localparam int IPQ_EV_USED  = 0;
  localparam int IPQ_EV_START = 1;
endpackage

// File: rtl/ipq_input_stage.sv
module ipq_input_stage #(
  parameter int WORD_W = 16,
  parameter int HALVES = 2,
  localparam int FETCH_W = WORD_W * HALVES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              fill,
  input  logic [FETCH_W-1:0] fill_data,
  input  logic              pop,
  output logic              head_valid,
  output logic [WORD_W-1:0] head_word,
  output logic              empty
);
  // slot 0 holds the most significant word and is consumed first
  logic [HALVES-1:0]             val_q, val_d;
  logic [HALVES-1:0][WORD_W-1:0] dat_q, dat_d;
  logic [HALVES-1:0]             first_hot;

  always_comb begin
    first_hot = '0;
    for (int i = 0; i < HALVES; i++) begin
      if (val_q[i] && (first_hot == '0)) first_hot[i] = 1'b1;
    end
  end

  always_comb begin
    head_valid = |val_q;
    head_word  = '0;
    for (int i = 0; i < HALVES; i++) begin
      if (first_hot[i]) head_word = dat_q[i];
    end
  end

  assign empty = ~(|val_q);

  generate
    for (genvar h = 0; h < HALVES; h++) begin : g_half
      always_comb begin
        val_d[h] = val_q[h];
        dat_d[h] = dat_q[h];
        if (clr) begin
          val_d[h] = 1'b0;
        end else if (fill && empty) begin
          val_d[h] = 1'b1;
          dat_d[h] = fill_data[FETCH_W-1-h*WORD_W -: WORD_W];
        end else if (pop && first_hot[h]) begin
          val_d[h] = 1'b0;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          val_q[h] <= 1'b0;
        end else begin
          val_q[h] <= val_d[h];
        end
      end

      always_ff @(posedge clk) begin
        if (fill && empty && !clr) begin
          dat_q[h] <= dat_d[h];
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ipq_hold_stage.sv
module ipq_hold_stage #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic              drop,
  input  logic [WORD_W-1:0] din,
  output logic              valid,
  output logic [WORD_W-1:0] dout
);
  logic              valid_d;
  logic              data_en;
  logic [WORD_W-1:0] dout_q;

  always_comb begin
    valid_d = valid;
    if (clr) begin
      valid_d = 1'b0;
    end else if (load) begin
      valid_d = 1'b1;
    end else if (drop) begin
      valid_d = 1'b0;
    end
  end

  assign data_en = load && !clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      dout_q <= '0;
    end else begin
      valid <= valid_d;
      if (data_en) dout_q <= din;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/ipq_status.sv
module ipq_status #(
  parameter int NLINES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] event_hit,
  output logic [NLINES-1:0] event_n
);
  generate
    for (genvar k = 0; k < NLINES; k++) begin : g_line
      logic line_d;
      assign line_d = ~event_hit[k];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          event_n[k] <= 1'b1;
        end else begin
          event_n[k] <= line_d;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/ipq_top.sv
module ipq_top #(
  parameter int WORD_W = ipq_pkg::IPQ_WORD_W,
  localparam int FETCH_W = WORD_W * ipq_pkg::IPQ_HALVES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               flush,
  output logic               fetch_req,
  input  logic               fetch_valid,
  input  logic [FETCH_W-1:0] fetch_data,
  input  logic               use_mid,
  input  logic               start_insn,
  output logic               mid_valid,
  output logic [WORD_W-1:0]  mid_word,
  output logic               dec_valid,
  output logic [WORD_W-1:0]  dec_word,
  output logic               used_n,
  output logic               start_n
);
  import ipq_pkg::*;

  logic              in_head_v;
  logic [WORD_W-1:0] in_head_w;
  logic              in_empty;
  logic              use_acc, start_acc, take;
  logic              mid_room, mid_load, mid_drop;
  logic [IPQ_NSTAT-1:0] ev_hit, ev_n;

  // acceptance of execution-unit requests
  always_comb begin
    use_acc   = mid_valid && use_mid && !flush;
    start_acc = mid_valid && start_insn && !flush;
    take      = use_acc || start_acc;
    mid_room  = !mid_valid || take;
    mid_load  = mid_room && in_head_v;
    mid_drop  = take && !in_head_v;
  end

  assign fetch_req = in_empty;

  ipq_input_stage #(
    .WORD_W (WORD_W),
    .HALVES (IPQ_HALVES)
  ) u_input (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (flush),
    .fill       (fetch_valid),
    .fill_data  (fetch_data),
    .pop        (mid_load),
    .head_valid (in_head_v),
    .head_word  (in_head_w),
    .empty      (in_empty)
  );

  ipq_hold_stage #(.WORD_W(WORD_W)) u_mid (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (flush),
    .load  (mid_load),
    .drop  (mid_drop),
    .din   (in_head_w),
    .valid (mid_valid),
    .dout  (mid_word)
  );

  ipq_hold_stage #(.WORD_W(WORD_W)) u_dec (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (flush),
    .load  (start_acc),
    .drop  (1'b0),
    .din   (mid_word),
    .valid (dec_valid),
    .dout  (dec_word)
  );

  always_comb begin
    ev_hit = '0;
    ev_hit[IPQ_EV_USED]  = use_acc;
    ev_hit[IPQ_EV_START] = start_acc;
  end

  ipq_status #(.NLINES(IPQ_NSTAT)) u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .event_hit (ev_hit),
    .event_n   (ev_n)
  );

  assign used_n  = ev_n[IPQ_EV_USED];
  assign start_n = ev_n[IPQ_EV_START];
endmodule

// File: rtl/ipq_checker.sv
module ipq_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              fetch_req,
  input logic              use_mid,
  input logic              start_insn,
  input logic              mid_valid,
  input logic [WORD_W-1:0] mid_word,
  input logic              dec_valid,
  input logic [WORD_W-1:0] dec_word,
  input logic              used_n,
  input logic              start_n
);
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (!mid_valid && !dec_valid && fetch_req && used_n && start_n)); // R10

  AST_USED_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_valid && use_mid && !flush) |=> !used_n); // R7

  AST_USED_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    !used_n |-> $past(mid_valid && use_mid && !flush)); // R7

  AST_START_LOADS_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_valid && start_insn && !flush) |=> (!start_n && dec_valid && dec_word == $past(mid_word))); // R5

  AST_DEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(mid_valid && start_insn) && !flush) |=> ($stable(dec_valid) && $stable(dec_word))); // R11

  AST_AUTO_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (!mid_valid && !fetch_req && !flush) |=> mid_valid); // R3
endmodule

bind ipq_top ipq_checker #(.WORD_W(WORD_W)) u_ipq_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .flush      (flush),
  .fetch_req  (fetch_req),
  .use_mid    (use_mid),
  .start_insn (start_insn),
  .mid_valid  (mid_valid),
  .mid_word   (mid_word),
  .dec_valid  (dec_valid),
  .dec_word   (dec_word),
  .used_n     (used_n),
  .start_n    (start_n)
);

// File: tb/ipq_top_bench.sv
module ipq_top_bench;
  logic        clk;
  logic        rst_n;
  logic        flush;
  logic        fetch_req;
  logic        fetch_valid;
  logic [31:0] fetch_data;
  logic        use_mid;
  logic        start_insn;
  logic        mid_valid;
  logic [15:0] mid_word;
  logic        dec_valid;
  logic [15:0] dec_word;
  logic        used_n;
  logic        start_n;

  int checks;
  int fails;
  int cycles;
  string tag;
  logic [15:0] lf;

  // behavioural reference model
  int q[$];
  bit mv, dv, un, sn;
  int md, dd;

  ipq_top u_ipq_top (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .fetch_req   (fetch_req),
    .fetch_valid (fetch_valid),
    .fetch_data  (fetch_data),
    .use_mid     (use_mid),
    .start_insn  (start_insn),
    .mid_valid   (mid_valid),
    .mid_word    (mid_word),
    .dec_valid   (dec_valid),
    .dec_word    (dec_word),
    .used_n      (used_n),
    .start_n     (start_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cycles, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // model update at the rising edge, from model state and driven inputs
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      q.delete(); mv = 0; dv = 0; un = 1; sn = 1; md = 0; dd = 0;
    end else if (flush) begin
      q.delete(); mv = 0; dv = 0; un = 1; sn = 1;
    end else begin
      bit tk, st, room, can_fill;
      tk = mv && (use_mid || start_insn);
      st = mv && start_insn;
      un = !(mv && use_mid);
      sn = !st;
      if (st) begin dd = md; dv = 1; end
      room = !mv || tk;
      can_fill = fetch_valid && (q.size() == 0);
      if (room) begin
        if (q.size() > 0) begin md = q.pop_front(); mv = 1; end
        else mv = 0;
      end
      if (can_fill) begin
        q.push_back(int'(fetch_data[31:16]));
        q.push_back(int'(fetch_data[15:0]));
      end
    end
    if (cycles > 20000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  // compare at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      chk({"R6 ", tag}, 32'(fetch_req), 32'(q.size() == 0));
      chk({"R3 R4 ", tag}, 32'(mid_valid), 32'(mv));
      if (mv) chk({"R2 R4 ", tag}, 32'(mid_word), 32'(md));
      chk({"R5 ", tag}, 32'(dec_valid), 32'(dv));
      if (dv) chk({"R5 ", tag}, 32'(dec_word), 32'(dd));
      chk({"R7 ", tag}, 32'(used_n), 32'(un));
      chk({"R8 ", tag}, 32'(start_n), 32'(sn));
    end
  end

  task automatic drive(input bit f, input bit fv, input logic [31:0] fd, input bit u, input bit s);
    @(negedge clk);
    #1;
    flush = f; fetch_valid = fv; fetch_data = fd; use_mid = u; start_insn = s;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(0, 0, 32'h0, 0, 0);
  endtask

  initial begin
    checks = 0; fails = 0; cycles = 0; tag = "";
    rst_n = 1'b0; flush = 0; fetch_valid = 0; fetch_data = 0; use_mid = 0; start_insn = 0;
    lf = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1 mid_valid", 32'(mid_valid), 0);
    chk("R1 dec_valid", 32'(dec_valid), 0);
    chk("R1 fetch_req", 32'(fetch_req), 1);
    chk("R1 used_n", 32'(used_n), 1);
    chk("R1 start_n", 32'(start_n), 1);
    #1 rst_n = 1'b1;

    tag = "R2 R3 fetch and drain";
    drive(0, 1, 32'hA1A2_B1B2, 0, 0);
    idle(3);
    drive(0, 0, 0, 1, 0);       // consume upper, lower flows in
    drive(0, 0, 0, 1, 0);       // consume lower, mid empties
    idle(2);

    tag = "R6 fetch held high with consumes";
    for (int i = 0; i < 12; i++) drive(0, 1, {16'h1000 + 16'(i), 16'h2000 + 16'(i)}, (i % 3) != 0, 0);
    idle(2);

    tag = "R5 R8 starts";
    drive(0, 1, 32'h4E71_4E75, 0, 0);
    idle(2);
    drive(0, 0, 0, 0, 1);
    drive(0, 0, 0, 0, 1);
    idle(2);

    tag = "R9 both together";
    drive(0, 1, 32'h3333_4444, 0, 0);
    idle(2);
    drive(0, 0, 0, 1, 1);
    drive(0, 0, 0, 1, 1);
    idle(2);

    tag = "R11 requests while empty";
    drive(0, 0, 0, 1, 1);
    drive(0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 1);
    idle(2);

    tag = "R10 flush";
    drive(0, 1, 32'h5555_6666, 0, 0);
    idle(1);
    drive(1, 1, 32'h7777_8888, 1, 1);
    drive(0, 0, 0, 1, 1);
    idle(2);
    drive(0, 1, 32'h9999_AAAA, 0, 0);
    idle(3);
    drive(1, 0, 0, 0, 0);
    idle(2);

    tag = "mixed";
    for (int i = 0; i < 400; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drive(lf[3:0] == 4'h0, lf[5] | lf[6], {lf, ~lf}, lf[7], lf[8] & lf[9]);
    end
    idle(3);
    finish_run();
  end
endmodule